// File: doc/BRIEF.md
# Even/Odd Banked Register File with Write Forwarding

This block stores the operand registers of an execution datapath: 32 registers of 32 bits, held as two banks of 16. Even-numbered registers live in one bank and odd-numbered ones in the other. Because the banks are separate, one write port can fill an aligned even/odd pair in a single cycle. It puts one lane into each bank, so a 64-bit result, or a 40-bit result with an 8-bit upper part, needs no extra write ports.

Results offered on a write port are held for one cycle in a pending stage and reach the bank storage at the following clock edge. A read that targets a register written in the current cycle, or one still sitting in the pending stage, takes its value from that write data and not from the storage. For such a read, the bank read enable of that port stays low, so the storage does no work in that cycle.

Read results are registered and appear one clock after the address is sampled. The number of write ports and of read ports are parameters, with defaults of 2 and 4.

Top module: `rfb_regfile`

## Requirements
- R1: A single write (`wr_mode` 0) puts `wr_lo` into register `wr_addr`. Address bit 0 selects the bank: 0 for even, 1 for odd. A later read of that register returns the value.
- R2: A 64-bit pair write (`wr_mode` 1) puts `wr_lo` into register `wr_addr` with bit 0 cleared and `wr_hi` into that register with bit 0 set, both in the same cycle. Bit 0 of `wr_addr` is ignored.
- R3: A 40-bit pair write (`wr_mode` 2) puts `wr_lo` into the even register of the pair and `{24'b0, wr_hi[7:0]}` into the odd one. `wr_mode` 3 behaves exactly as a single write.
- R4: `rd_data[r]` is updated at the clock edge that samples `rd_en[r]` high. It shows the register as modified by every write offered in that same cycle and in earlier cycles.
- R5: A write is committed to the bank storage one edge after it is offered. `rd_fwd[r]` is high after a read of a register written in the same cycle or in the cycle before, and low after a read served by the storage.
- R6: `rd_arr_en[r]` is high only when `rd_en[r]` is high and the read is not served by forwarding. When it is low, the bank read outputs of that port keep their value.
- R7: When several write ports write the same register in one cycle, the highest-numbered port's data is kept, both for forwarding and in storage.
- R8: `wr_conflict` is high for exactly the cycle after a cycle in which two write ports target a common register. Overlap through one half of a pair write also counts.
- R9: While `rd_en[r]` is low, `rd_data[r]` and `rd_fwd[r]` hold their values.
- R10: Synchronous reset clears `rd_data`, `rd_fwd`, `wr_conflict` and the pending stage. Register contents are undefined until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NW | Write request per write port |
| wr_mode | input | NW x 2 | 0 single, 1 pair 64-bit, 2 pair 40-bit, 3 single |
| wr_addr | input | NW x 5 | Target register (bit 0 ignored for pairs) |
| wr_lo | input | NW x 32 | Low / single write data |
| wr_hi | input | NW x 32 | High data for pair writes |
| rd_en | input | NR | Read request per read port |
| rd_addr | input | NR x 5 | Register to read |
| rd_data | output | NR x 32 | Registered read result |
| rd_fwd | output | NR | Last read was served by forwarding |
| rd_arr_en | output | NR | Bank read enable of each port this cycle |
| wr_conflict | output | 1 | Two ports hit one register in the previous cycle |

## Verification
Forwarding and commit can coincide. A register may be in the pending stage while the same register, or its pair partner, is written again on the live ports, and a read of it is requested in that cycle. The bench provokes this with directed back-to-back writes and reads of one register. It also runs random traffic confined to eight registers, so that same-cycle writes, pending writes and overlapping pair writes all occur often. A shadow model applies each cycle's writes in port order and judges the registered read data, the forwarding flag, the combinational read enable and the conflict flag.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  typedef enum logic [1:0] {
    WM_SINGLE = 2'd0,
    WM_PAIR64 = 2'd1,
    WM_PAIR40 = 2'd2,
    WM_ALT    = 2'd3
  } wmode_e;
endpackage

// File: rtl/rfb_wr_decode.sv
module rfb_wr_decode #(
  parameter int DW     = 32,
  parameter int AW     = 5,
  parameter int NARROW = 8
) (
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic          en_e,
  output logic          en_o,
  output logic [AW-2:0] idx,
  output logic [DW-1:0] d_e,
  output logic [DW-1:0] d_o
);
  import rfb_pkg::*;
  wmode_e m;

  always_comb begin
    m   = wmode_e'(mode);
    idx = addr[AW-1:1];
    d_e = lo;
    case (m)
      WM_PAIR64: begin
        en_e = en;
        en_o = en;
        d_o  = hi;
      end
      WM_PAIR40: begin
        en_e = en;
        en_o = en;
        d_o  = {{(DW-NARROW){1'b0}}, hi[NARROW-1:0]};
      end
      default: begin
        en_e = en & ~addr[0];
        en_o = en & addr[0];
        d_o  = lo;
      end
    endcase
  end
endmodule

// File: rtl/rfb_bank.sv
module rfb_bank #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int NW = 2,
  parameter int NR = 4,
  localparam int DEPTH = 1 << IW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NW-1:0]          we,
  input  logic [NW-1:0][IW-1:0]  widx,
  input  logic [NW-1:0][DW-1:0]  wd,
  input  logic [NR-1:0]          re,
  input  logic [NR-1:0][IW-1:0]  ridx,
  output logic [NR-1:0][DW-1:0]  q
);
  logic [DW-1:0] mem [DEPTH];

  // later ports are applied last and therefore win
  always_ff @(posedge clk) begin
    for (int w = 0; w < NW; w++) begin
      if (we[w]) mem[widx[w]] <= wd[w];
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NR; r++) begin
      if (rst)        q[r] <= '0;
      else if (re[r]) q[r] <= mem[ridx[r]];
    end
  end
endmodule

// File: rtl/rfb_fwd.sv
module rfb_fwd #(
  parameter int DW = 32,
  parameter int IW = 4,
  parameter int NW = 2
) (
  input  logic                  bank,
  input  logic [IW-1:0]         ridx,
  input  logic [NW-1:0]         c_en_e,
  input  logic [NW-1:0]         c_en_o,
  input  logic [NW-1:0][IW-1:0] c_idx,
  input  logic [NW-1:0][DW-1:0] c_de,
  input  logic [NW-1:0][DW-1:0] c_do,
  input  logic [NW-1:0]         p_en_e,
  input  logic [NW-1:0]         p_en_o,
  input  logic [NW-1:0][IW-1:0] p_idx,
  input  logic [NW-1:0][DW-1:0] p_de,
  input  logic [NW-1:0][DW-1:0] p_do,
  output logic                  hit,
  output logic [DW-1:0]         data
);
  // older (pending) first, then live ports; the last match overrides
  always_comb begin
    hit  = 1'b0;
    data = '0;
    for (int w = 0; w < NW; w++) begin
      if ((bank ? p_en_o[w] : p_en_e[w]) && p_idx[w] == ridx) begin
        hit  = 1'b1;
        data = bank ? p_do[w] : p_de[w];
      end
    end
    for (int w = 0; w < NW; w++) begin
      if ((bank ? c_en_o[w] : c_en_e[w]) && c_idx[w] == ridx) begin
        hit  = 1'b1;
        data = bank ? c_do[w] : c_de[w];
      end
    end
  end
endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile #(
  parameter int NW     = 2,
  parameter int NR     = 4,
  parameter int DW     = 32,
  parameter int NREGS  = 32,
  parameter int NARROW = 8,
  localparam int AW    = $clog2(NREGS),
  localparam int IW    = AW - 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NW-1:0]         wr_en,
  input  logic [NW-1:0][1:0]    wr_mode,
  input  logic [NW-1:0][AW-1:0] wr_addr,
  input  logic [NW-1:0][DW-1:0] wr_lo,
  input  logic [NW-1:0][DW-1:0] wr_hi,
  input  logic [NR-1:0]         rd_en,
  input  logic [NR-1:0][AW-1:0] rd_addr,
  output logic [NR-1:0][DW-1:0] rd_data,
  output logic [NR-1:0]         rd_fwd,
  output logic [NR-1:0]         rd_arr_en,
  output logic                  wr_conflict
);
  logic [NW-1:0]         c_en_e, c_en_o, p_en_e, p_en_o;
  logic [NW-1:0][IW-1:0] c_idx, p_idx;
  logic [NW-1:0][DW-1:0] c_de, c_do, p_de, p_do;
  logic [NR-1:0]         hit, sel_q, bsel_q, re_e, re_o;
  logic [NR-1:0][DW-1:0] fdata, fwd_q, q_e, q_o;
  logic [NR-1:0][IW-1:0] ridx;
  logic                  cf;

  for (genvar w = 0; w < NW; w++) begin : g_wr
    rfb_wr_decode #(.DW(DW), .AW(AW), .NARROW(NARROW)) i_dec (
      .en(wr_en[w]), .mode(wr_mode[w]), .addr(wr_addr[w]),
      .lo(wr_lo[w]), .hi(wr_hi[w]),
      .en_e(c_en_e[w]), .en_o(c_en_o[w]), .idx(c_idx[w]),
      .d_e(c_de[w]), .d_o(c_do[w])
    );
  end

  // pending stage: results wait here one cycle before commit
  always_ff @(posedge clk) begin
    if (rst) begin
      p_en_e <= '0;
      p_en_o <= '0;
    end else begin
      p_en_e <= c_en_e;
      p_en_o <= c_en_o;
    end
  end

  always_ff @(posedge clk) begin
    p_idx <= c_idx;
    p_de  <= c_de;
    p_do  <= c_do;
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign ridx[r] = rd_addr[r][AW-1:1];
    rfb_fwd #(.DW(DW), .IW(IW), .NW(NW)) i_fwd (
      .bank(rd_addr[r][0]), .ridx(ridx[r]),
      .c_en_e(c_en_e), .c_en_o(c_en_o), .c_idx(c_idx), .c_de(c_de), .c_do(c_do),
      .p_en_e(p_en_e), .p_en_o(p_en_o), .p_idx(p_idx), .p_de(p_de), .p_do(p_do),
      .hit(hit[r]), .data(fdata[r])
    );
    assign rd_arr_en[r] = rd_en[r] & ~hit[r];
    assign re_e[r]      = rd_arr_en[r] & ~rd_addr[r][0];
    assign re_o[r]      = rd_arr_en[r] &  rd_addr[r][0];
  end

  rfb_bank #(.DW(DW), .IW(IW), .NW(NW), .NR(NR)) i_bank_even (
    .clk(clk), .rst(rst), .we(p_en_e), .widx(p_idx), .wd(p_de),
    .re(re_e), .ridx(ridx), .q(q_e)
  );

  rfb_bank #(.DW(DW), .IW(IW), .NW(NW), .NR(NR)) i_bank_odd (
    .clk(clk), .rst(rst), .we(p_en_o), .widx(p_idx), .wd(p_do),
    .re(re_o), .ridx(ridx), .q(q_o)
  );

  always_comb begin
    cf = 1'b0;
    for (int i = 0; i < NW; i++) begin
      for (int j = i + 1; j < NW; j++) begin
        if (c_idx[i] == c_idx[j] &&
            ((c_en_e[i] && c_en_e[j]) || (c_en_o[i] && c_en_o[j])))
          cf = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      bsel_q      <= '0;
      fwd_q       <= '0;
      wr_conflict <= 1'b0;
    end else begin
      wr_conflict <= cf;
      for (int r = 0; r < NR; r++) begin
        if (rd_en[r]) begin
          sel_q[r]  <= hit[r];
          bsel_q[r] <= rd_addr[r][0];
          fwd_q[r]  <= fdata[r];
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < NR; r++) begin
      rd_data[r] = sel_q[r] ? fwd_q[r] : (bsel_q[r] ? q_o[r] : q_e[r]);
    end
  end
  assign rd_fwd = sel_q;

  AST_CONFLICT_TWO_WRITERS: assert property (@(posedge clk) disable iff (rst)
    wr_conflict |-> $countones($past(wr_en)) >= 2); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!wr_conflict && rd_fwd == '0 && p_en_e == '0 && p_en_o == '0)); // R10

  for (genvar w = 0; w < NW; w++) begin : g_wa
    AST_PENDING_FROM_PORT: assert property (@(posedge clk) disable iff (rst)
      (p_en_e[w] || p_en_o[w]) |-> $past(wr_en[w])); // R5
  end

  for (genvar r = 0; r < NR; r++) begin : g_ra
    AST_FWD_BANKS_IDLE: assert property (@(posedge clk) disable iff (rst)
      rd_fwd[r] |-> ($stable(q_e[r]) && $stable(q_o[r]))); // R6
    AST_HOLD_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
      !$past(rd_en[r]) |-> ($stable(rd_data[r]) && $stable(rd_fwd[r]))); // R9
  end
endmodule

// File: tb/test_rfb_regfile.sv
module test_rfb_regfile;
  localparam int PERIOD = 10;
  localparam int NW = 2;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]        wr_en = '0;
  logic [NW-1:0][1:0]   wr_mode = '0;
  logic [NW-1:0][4:0]   wr_addr = '0;
  logic [NW-1:0][31:0]  wr_lo = '0;
  logic [NW-1:0][31:0]  wr_hi = '0;
  logic [NR-1:0]        rd_en = '0;
  logic [NR-1:0][4:0]   rd_addr = '0;
  logic [NR-1:0][31:0]  rd_data;
  logic [NR-1:0]        rd_fwd;
  logic [NR-1:0]        rd_arr_en;
  logic                 wr_conflict;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;
  logic [31:0] sh [32];
  int          wcyc [32];
  logic [31:0] exp_data [NR];
  logic        exp_fwd [NR];

  always #(PERIOD/2) clk = ~clk;

  rfb_regfile #(.NW(NW), .NR(NR)) i_rfb_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_fwd(rd_fwd), .rd_arr_en(rd_arr_en),
    .wr_conflict(wr_conflict)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] tmask(input logic en, input logic [1:0] m, input logic [4:0] a);
    logic [31:0] k = '0;
    if (en) begin
      if (m == 2'd1 || m == 2'd2) begin
        k[{a[4:1], 1'b0}] = 1'b1;
        k[{a[4:1], 1'b1}] = 1'b1;
      end else k[a] = 1'b1;
    end
    return k;
  endfunction

  // one clock: applies the live inputs to the model and checks all outputs
  task automatic step(input string tag);
    logic exp_conf = 1'b0;
    logic [NR-1:0] exp_arr = '0;
    for (int i = 0; i < NW; i++)
      for (int j = i + 1; j < NW; j++)
        if ((tmask(wr_en[i], wr_mode[i], wr_addr[i]) & tmask(wr_en[j], wr_mode[j], wr_addr[j])) != 0)
          exp_conf = 1'b1;
    for (int w = 0; w < NW; w++) begin
      if (wr_en[w]) begin
        logic [4:0] e = {wr_addr[w][4:1], 1'b0};
        logic [4:0] o = {wr_addr[w][4:1], 1'b1};
        if (wr_mode[w] == 2'd1) begin
          sh[e] = wr_lo[w]; sh[o] = wr_hi[w]; wcyc[e] = cyc; wcyc[o] = cyc;
        end else if (wr_mode[w] == 2'd2) begin
          sh[e] = wr_lo[w]; sh[o] = {24'b0, wr_hi[w][7:0]}; wcyc[e] = cyc; wcyc[o] = cyc;
        end else begin
          sh[wr_addr[w]] = wr_lo[w]; wcyc[wr_addr[w]] = cyc;
        end
      end
    end
    for (int r = 0; r < NR; r++) begin
      if (rd_en[r]) begin
        exp_fwd[r]  = (wcyc[rd_addr[r]] >= cyc - 1);
        exp_data[r] = sh[rd_addr[r]];
        exp_arr[r]  = !exp_fwd[r];
      end
    end
    #2;
    for (int r = 0; r < NR; r++)
      chk(rd_arr_en[r] == exp_arr[r], "R6", 32'(rd_arr_en[r]), 32'(exp_arr[r]));
    @(posedge clk); #1;
    for (int r = 0; r < NR; r++) begin
      chk(rd_data[r] == exp_data[r], tag, rd_data[r], exp_data[r]);
      chk(rd_fwd[r] == exp_fwd[r], "R5", 32'(rd_fwd[r]), 32'(exp_fwd[r]));
    end
    chk(wr_conflict == exp_conf, "R8", 32'(wr_conflict), 32'(exp_conf));
    cyc++;
  endtask

  task automatic wr(input int p, input logic [1:0] m, input logic [4:0] a, input logic [31:0] lo, input logic [31:0] hi);
    wr_en[p] = 1'b1; wr_mode[p] = m; wr_addr[p] = a; wr_lo[p] = lo; wr_hi[p] = hi;
  endtask

  task automatic rd(input int p, input logic [4:0] a);
    rd_en[p] = 1'b1; rd_addr[p] = a;
  endtask

  task automatic idle_inputs();
    wr_en = '0; rd_en = '0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) begin sh[i] = '0; wcyc[i] = -100; end
    for (int r = 0; r < NR; r++) begin exp_data[r] = '0; exp_fwd[r] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10 reset state
    for (int r = 0; r < NR; r++) begin
      chk(rd_data[r] == 0, "R10", rd_data[r], 0);
      chk(rd_fwd[r] == 0, "R10", 32'(rd_fwd[r]), 0);
      chk(rd_arr_en[r] == 0, "R10", 32'(rd_arr_en[r]), 0);
    end
    chk(wr_conflict == 0, "R10", 32'(wr_conflict), 0);

    // R1 fill every register with single writes
    for (int k = 0; k < 16; k++) begin
      idle_inputs();
      wr(0, 2'd0, 5'(2*k), $urandom, 0);
      wr(1, 2'd0, 5'(2*k+1), $urandom, 0);
      step("R1");
    end
    idle_inputs(); step("R1");
    idle_inputs(); step("R1");
    for (int k = 0; k < 8; k++) begin
      idle_inputs();
      for (int r = 0; r < NR; r++) rd(r, 5'(4*k + r));
      step("R1");
    end

    // R4 same-cycle read, then pending read (R5), then array read
    idle_inputs(); wr(0, 2'd0, 5'd3, 32'hCAFE0003, 0); rd(0, 5'd3); rd(1, 5'd2); step("R4");
    idle_inputs(); rd(0, 5'd3); step("R5");
    idle_inputs(); rd(0, 5'd3); step("R5");

    // R2 pair 64 with odd address bit ignored
    idle_inputs(); wr(1, 2'd1, 5'd9, 32'h11112222, 32'h33334444); step("R2");
    idle_inputs(); idle_inputs(); step("R2");
    idle_inputs(); rd(0, 5'd8); rd(1, 5'd9); step("R2");

    // R3 pair 40 and alternate single encoding
    idle_inputs(); wr(0, 2'd2, 5'd12, 32'hAAAA5555, 32'hFFFFFF7E); rd(2, 5'd13); step("R3");
    idle_inputs(); rd(2, 5'd12); rd(3, 5'd13); step("R3");
    idle_inputs(); step("R3");
    idle_inputs(); rd(0, 5'd13); wr(1, 2'd3, 5'd21, 32'h0BADF00D, 32'h12345678); step("R3");
    idle_inputs(); step("R3");
    idle_inputs(); rd(0, 5'd21); rd(1, 5'd20); step("R3");

    // R7 both ports hit one register
    idle_inputs(); wr(0, 2'd0, 5'd5, 32'h00000A0A, 0); wr(1, 2'd0, 5'd5, 32'h00000B0B, 0); rd(0, 5'd5); step("R7");
    idle_inputs(); rd(1, 5'd5); step("R7");
    idle_inputs(); rd(2, 5'd5); step("R7");
    // R8 overlap through half of a pair
    idle_inputs(); wr(0, 2'd1, 5'd6, 32'h66666666, 32'h77777777); wr(1, 2'd0, 5'd7, 32'h70707070, 0); step("R8");
    idle_inputs(); step("R8");
    idle_inputs(); rd(0, 5'd6); rd(1, 5'd7); step("R8");

    // R9 no read requested: outputs hold while writes go on
    idle_inputs(); wr(0, 2'd0, 5'd7, 32'hDEAD0007, 0); step("R9");
    idle_inputs(); step("R9");

    // random traffic on a small register window
    for (int n = 0; n < 3000; n++) begin
      idle_inputs();
      for (int w = 0; w < NW; w++)
        if ($urandom_range(0, 1) == 1)
          wr(w, 2'($urandom_range(0, 3)), 5'($urandom_range(0, 7)), $urandom, $urandom);
      for (int r = 0; r < NR; r++)
        if ($urandom_range(0, 2) != 0) rd(r, 5'($urandom_range(0, 7)));
      step("R4");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog at cycle %0d: actual running expected finished", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule